// File: doc/BRIEF.md
# Clock Rate Divider with Square Wave and Event Status

This block sits behind the oscillator of a real-time clock. It counts a 32.768 kHz enable pulse through a 15-stage binary divider. The divider yields a one-cycle pulse once per second for the calendar engine, and a set of intermediate taps. A 4-bit rate code picks one tap. That tap feeds a square-wave pin and raises a periodic event each time it completes a period.

The block also owns the event status byte. That byte holds periodic, alarm and update-ended flags plus a summary interrupt flag. From it the block drives an active-low interrupt request, modelled as an open-drain pin through a separate output enable. Software clears every flag and releases the request by reading the status byte.

Top module: `rtc_rate_irq`

## Requirements
- R1: The divider advances on `osc_tick` only while `osc_ctl` equals 3'b010. Any other value holds it at zero, so the square wave stays low and no periodic event or seconds pulse occurs. This includes 3'b11x, which keeps the oscillator running but stops the divider.
- R2: For a nonzero `rate_sel`, the square-wave period in ticks is 2^7 for code 1 and 2^8 for code 2. For codes 3 to 15 it is 2^(code-1), which runs from 8.192 kHz down to 2 Hz. The output is low for the first half of each period, starting from divider zero.
- R3: `rate_sel` = 0 selects no tap: `sqw` stays low and no periodic event is raised.
- R4: While `sqw_en` is 0, `sqw` is held low.
- R5: `sec_tick` is a single-cycle pulse one clock after the tick that wraps the divider, which happens once every 2^15 ticks.
- R6: The periodic flag (status bit 6) is set one clock after the tick on which the selected tap falls from 1 to 0, which happens once per tap period.
- R7: A pulse on `alarm_evt` sets status bit 5 and a pulse on `update_evt` sets status bit 4, each on the next clock. Status bits 3:0 always read 0.
- R8: Status bit 7 is 1 exactly when some flag is set and its enable (`pie` for bit 6, `aie` for bit 5, `uie` for bit 4) was 1 at the clock that updated the flags.
- R9: `irq_oe` is 1 and `irq_n` is 0 exactly while status bit 7 is 1. Otherwise `irq_oe` is 0 and `irq_n` is 1.
- R10: A clock with `stat_rd` high clears all flags and releases the interrupt, unless an event arrives in that same clock.
- R11: An event that coincides with `stat_rd` wins. Its flag is set after that clock, while the other flags are cleared.
- R12: The synchronous reset `rst` clears the divider, all status flags and the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | 32.768 kHz enable pulse |
| osc_ctl | input | 3 | Oscillator/divider control field, 3'b010 = run |
| rate_sel | input | 4 | Tap select for square wave and periodic event |
| sqw_en | input | 1 | Square-wave output enable |
| pie | input | 1 | Periodic event interrupt enable |
| aie | input | 1 | Alarm event interrupt enable |
| uie | input | 1 | Update-ended event interrupt enable |
| alarm_evt | input | 1 | Alarm match pulse from the calendar engine |
| update_evt | input | 1 | Update-cycle-ended pulse from the calendar engine |
| stat_rd | input | 1 | Status byte read strobe, one clock per read |
| sqw | output | 1 | Square-wave output |
| sec_tick | output | 1 | One-cycle pulse per 2^15 ticks |
| stat_byte | output | 8 | {irq flag, periodic, alarm, update, 4'b0} |
| irq_n | output | 1 | Active-low interrupt request level |
| irq_oe | output | 1 | Drive enable of the open-drain interrupt pin |

## Verification
`sqw` is combinational from the registered divider and the current rate and enable inputs. It is due in the same cycle as the divider value it reflects. `sec_tick`, every status bit and the interrupt pins each go through one register, so they are due one clock after the tick, event or read that causes them. The bench drives inputs on the falling edge and updates a reference model at each rising edge from those same inputs. It compares every output on the next falling edge, which is the first point at which each result is due.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;

    localparam int DIV_W  = 15;
    localparam int RATE_W = 4;

    typedef enum logic [1:0] {
        OSC_STOPPED,
        OSC_DIV_HELD,
        OSC_RUNNING
    } osc_mode_e;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } evt_flags_t;

    function automatic osc_mode_e decode_osc(input logic [2:0] ctl);
        if (ctl == 3'b010)
            return OSC_RUNNING;
        else if (ctl[2:1] == 2'b11)
            return OSC_DIV_HELD;
        else
            return OSC_STOPPED;
    endfunction

    // Divider bit that forms the selected tap; codes 1 and 2 reuse slow taps.
    function automatic int unsigned tap_bit(input logic [RATE_W-1:0] code);
        case (code)
            4'd0:    return 0;
            4'd1:    return 6;
            4'd2:    return 7;
            default: return int'(code) - 2;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_rate_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         osc_tick,
    input  logic [2:0]   osc_ctl,
    output logic [W-1:0] cnt,
    output logic         div_run,
    output logic         sec_tick
);
    osc_mode_e mode;

    always_comb begin
        mode    = decode_osc(osc_ctl);
        div_run = (mode == OSC_RUNNING);
    end

    always_ff @(posedge clk) begin
        if (rst || !div_run)
            cnt <= '0;
        else if (osc_tick)
            cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sec_tick <= 1'b0;
        else
            sec_tick <= div_run && osc_tick && (&cnt);
    end

    // R1: a stopped or held divider sits at zero
    a_r1_div_held: assert property (@(posedge clk) disable iff (rst)
        (decode_osc(osc_ctl) != OSC_RUNNING) |=> (cnt == '0));

    // R5: the seconds pulse lands exactly on the wrap to zero
    a_r5_tick_on_wrap: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> (cnt == '0));

endmodule

// File: rtl/rtc_tap_mux.sv
module rtc_tap_mux
    import rtc_rate_pkg::*;
#(
    parameter int W  = DIV_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  cnt,
    input  logic          div_run,
    input  logic          osc_tick,
    input  logic [RW-1:0] rate_sel,
    input  logic          sqw_en,
    output logic          sqw,
    output logic          per_evt
);
    logic [W-1:0] ones_below;
    logic         tap_on;
    logic         tap_val;
    logic         tap_wrap;
    int unsigned  sel_bit;

    // ones_below[i]: divider bits i..0 are all 1, so bit i falls on the next tick
    assign ones_below[0] = cnt[0];
    generate
        for (genvar i = 1; i < W; i++) begin : g_chain
            assign ones_below[i] = ones_below[i-1] & cnt[i];
        end
    endgenerate

    always_comb begin
        sel_bit  = tap_bit(rate_sel);
        tap_on   = (rate_sel != '0);
        tap_val  = 1'b0;
        tap_wrap = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (sel_bit == k) begin
                tap_val  = cnt[k];
                tap_wrap = ones_below[k];
            end
        end
        sqw     = sqw_en && tap_on && tap_val;
        per_evt = div_run && osc_tick && tap_on && tap_wrap;
    end

    // R3: no periodic event with the tap deselected
    a_r3_no_event_when_off: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == '0) |-> !per_evt);

endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags
    import rtc_rate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       per_evt,
    input  logic       alarm_evt,
    input  logic       update_evt,
    input  logic       stat_rd,
    input  logic       pie,
    input  logic       aie,
    input  logic       uie,
    output logic [7:0] stat_byte,
    output logic       intf
);
    evt_flags_t flags_q, flags_d, evt_now, en_now;
    logic       intf_d;

    always_comb begin
        evt_now = '{per: per_evt, alm: alarm_evt, upd: update_evt};
        en_now  = '{per: pie, alm: aie, upd: uie};
        // an event in the reading clock survives the clear
        flags_d = stat_rd ? evt_now : (flags_q | evt_now);
        intf_d  = |(flags_d & en_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            intf    <= 1'b0;
        end else begin
            flags_q <= flags_d;
            intf    <= intf_d;
        end
    end

    assign stat_byte = {intf, flags_q.per, flags_q.alm, flags_q.upd, 4'b0000};

    // R7: an alarm pulse is visible on the next clock
    a_r7_alarm_sets: assert property (@(posedge clk) disable iff (rst)
        alarm_evt |=> flags_q.alm);

    // R8: the summary flag never stands without a flag under it
    a_r8_intf_has_source: assert property (@(posedge clk) disable iff (rst)
        intf |-> (flags_q != '0));

    // R10: a quiet read empties the register
    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !per_evt && !alarm_evt && !update_evt) |=> (flags_q == '0 && !intf));

    // R12: reset leaves nothing pending
    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (flags_q == '0 && !intf));

endmodule

// File: rtl/rtc_rate_irq.sv
module rtc_rate_irq
    import rtc_rate_pkg::*;
#(
    parameter int W  = DIV_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          osc_tick,
    input  logic [2:0]    osc_ctl,
    input  logic [RW-1:0] rate_sel,
    input  logic          sqw_en,
    input  logic          pie,
    input  logic          aie,
    input  logic          uie,
    input  logic          alarm_evt,
    input  logic          update_evt,
    input  logic          stat_rd,
    output logic          sqw,
    output logic          sec_tick,
    output logic [7:0]    stat_byte,
    output logic          irq_n,
    output logic          irq_oe
);
    logic [W-1:0] cnt;
    logic         div_run;
    logic         per_evt;
    logic         intf;

    rtc_prescaler #(.W(W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .osc_ctl  (osc_ctl),
        .cnt      (cnt),
        .div_run  (div_run),
        .sec_tick (sec_tick)
    );

    rtc_tap_mux #(.W(W), .RW(RW)) u_tap (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .div_run  (div_run),
        .osc_tick (osc_tick),
        .rate_sel (rate_sel),
        .sqw_en   (sqw_en),
        .sqw      (sqw),
        .per_evt  (per_evt)
    );

    rtc_event_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .per_evt    (per_evt),
        .alarm_evt  (alarm_evt),
        .update_evt (update_evt),
        .stat_rd    (stat_rd),
        .pie        (pie),
        .aie        (aie),
        .uie        (uie),
        .stat_byte  (stat_byte),
        .intf       (intf)
    );

    // open drain: the pin is driven only to pull low
    assign irq_oe = intf;
    assign irq_n  = ~intf;

    // R9: the pin pulls low while enabled and floats high otherwise
    a_r9_pin_pairing: assert property (@(posedge clk) disable iff (rst)
        irq_oe |-> (!irq_n && stat_byte[7]));

endmodule

// File: tb/tb_rtc_rate_irq.sv
module tb_rtc_rate_irq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic [2:0] osc_ctl = 3'b000;
    logic [3:0] rate_sel = 4'd0;
    logic       sqw_en = 1'b0;
    logic       pie = 1'b0, aie = 1'b0, uie = 1'b0;
    logic       alarm_evt = 1'b0, update_evt = 1'b0, stat_rd = 1'b0;
    logic       sqw, sec_tick, irq_n, irq_oe;
    logic [7:0] stat_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag_ovr = "";

    // reference model state
    int unsigned m = 0;
    bit m_pf = 0, m_af = 0, m_uf = 0, m_intf = 0, m_sec = 0;

    always #5 clk = ~clk;

    rtc_rate_irq dut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .osc_ctl(osc_ctl),
        .rate_sel(rate_sel), .sqw_en(sqw_en), .pie(pie), .aie(aie), .uie(uie),
        .alarm_evt(alarm_evt), .update_evt(update_evt), .stat_rd(stat_rd),
        .sqw(sqw), .sec_tick(sec_tick), .stat_byte(stat_byte),
        .irq_n(irq_n), .irq_oe(irq_oe)
    );

    // R2: square-wave period 2^p ticks; the tap is divider bit p-1
    function automatic int exp_bit(input logic [3:0] code);
        int p;
        if (code == 4'd1)      p = 7;
        else if (code == 4'd2) p = 8;
        else                   p = int'(code) - 1;
        return p - 1;
    endfunction

    always @(posedge clk) begin
        bit run, pev;
        int unsigned mask;
        if (rst) begin
            m = 0; m_pf = 0; m_af = 0; m_uf = 0; m_intf = 0; m_sec = 0;
        end else begin
            run  = (osc_ctl == 3'b010);
            mask = (rate_sel == 0) ? 0 : ((32'd1 << (exp_bit(rate_sel) + 1)) - 1);
            pev  = run && osc_tick && (rate_sel != 0) && ((m & mask) == mask);
            m_sec = run && osc_tick && (m == 32767);
            m_pf = pev        || (m_pf && !stat_rd);
            m_af = alarm_evt  || (m_af && !stat_rd);
            m_uf = update_evt || (m_uf && !stat_rd);
            m_intf = (m_pf && pie) || (m_af && aie) || (m_uf && uie);
            m = run ? ((m + (osc_tick ? 1 : 0)) & 32767) : 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string pick(input string dflt);
        return (tag_ovr != "") ? tag_ovr : dflt;
    endfunction

    task automatic do_checks();
        bit exp_sqw;
        string st;
        exp_sqw = sqw_en && (rate_sel != 0) && ((m >> exp_bit(rate_sel)) & 1);
        if (!sqw_en)               st = "R4";
        else if (rate_sel == 0)    st = "R3";
        else if (osc_ctl != 3'b010) st = "R1";
        else                       st = "R2";
        chk(pick(st), {31'd0, sqw}, {31'd0, exp_sqw});
        chk(pick("R5"), {31'd0, sec_tick}, {31'd0, m_sec});
        chk(pick("R6"), {31'd0, stat_byte[6]}, {31'd0, m_pf});
        chk(pick("R7"), {28'd0, stat_byte[5:2]}, {28'd0, m_af, m_uf, 2'b00});
        chk(pick("R7"), {30'd0, stat_byte[1:0]}, 32'd0);
        chk(pick("R8"), {31'd0, stat_byte[7]}, {31'd0, m_intf});
        chk(pick("R9"), {30'd0, irq_n, irq_oe}, {30'd0, !m_intf, m_intf});
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        do_checks();
    endtask

    task automatic pulse_clear();
        alarm_evt = 0; update_evt = 0; stat_rd = 0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R12: reset state
        tag_ovr = "R12";
        repeat (3) cyc();
        rst = 0;
        tag_ovr = "";

        // directed: fastest tap, periodic interrupt enabled
        osc_ctl = 3'b010; rate_sel = 4'd3; sqw_en = 1; osc_tick = 1; pie = 1;
        repeat (200) cyc();
        // slow repeat codes 1 and 2
        rate_sel = 4'd1; repeat (600) cyc();
        rate_sel = 4'd2; repeat (600) cyc();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            osc_tick = ($urandom % 4) != 0;
            if (i % 256 == 0) begin
                rate_sel = 4'($urandom % 16);
                sqw_en   = ($urandom % 4) != 0;
                osc_ctl  = (($urandom % 8) != 0) ? 3'b010 : 3'($urandom % 8);
            end
            if (i % 64 == 0) begin
                pie = 1'($urandom); aie = 1'($urandom); uie = 1'($urandom);
            end
            alarm_evt  = ($urandom % 50) == 0;
            update_evt = ($urandom % 50) == 0;
            stat_rd    = ($urandom % 40) == 0;
            cyc();
        end
        pulse_clear();

        // R1: divider held with 11x and stopped with 000
        tag_ovr = "R1";
        osc_ctl = 3'b110; rate_sel = 4'd3; sqw_en = 1; osc_tick = 1;
        repeat (300) cyc();
        osc_ctl = 3'b000; repeat (100) cyc();
        // R3: code zero
        tag_ovr = "R3";
        osc_ctl = 3'b010; rate_sel = 4'd0; repeat (300) cyc();
        // R4: enable low
        tag_ovr = "R4";
        rate_sel = 4'd4; sqw_en = 0; repeat (300) cyc();
        sqw_en = 1;

        // R10: read clears flags and releases interrupt
        tag_ovr = "R10";
        osc_ctl = 3'b000; aie = 1; uie = 1; pie = 1;
        alarm_evt = 1; update_evt = 1; cyc();
        pulse_clear(); cyc();
        stat_rd = 1; cyc();
        pulse_clear(); repeat (3) cyc();

        // R11: event coinciding with read wins
        tag_ovr = "R11";
        update_evt = 1; cyc();
        pulse_clear();
        alarm_evt = 1; stat_rd = 1; cyc();
        pulse_clear(); repeat (3) cyc();
        uie = 1; aie = 0; update_evt = 1; stat_rd = 1; cyc();
        pulse_clear(); repeat (2) cyc();

        // R5, R6: long run at the slowest tap
        tag_ovr = "";
        osc_ctl = 3'b010; rate_sel = 4'd15; osc_tick = 1; pie = 1;
        for (int i = 0; i < 70000; i++) begin
            stat_rd = (i % 5000) == 4999;
            cyc();
        end
        stat_rd = 0;

        // R12: reset mid-run with flags pending
        alarm_evt = 1; cyc(); pulse_clear();
        tag_ovr = "R12";
        rst = 1; repeat (2) cyc();
        rst = 0; repeat (20) cyc();
        tag_ovr = "";

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule